// File: doc/BRIEF.md
# Low-Side Switch Fault Supervisor

This block watches the raw fault comparators of a bank of low-side switch channels and turns them into clean fault indications. Each channel receives its commanded switch state, an open-load comparator bit and a short comparator bit. A comparator bit counts as a fault only after it has been asserted for a programmable number of consecutive clock cycles. This rejects the transients that follow a switching edge.

The two fault kinds behave differently. An open load is only examined while the switch is commanded off. Its flag follows the filtered condition and clears by itself once the condition goes away. A short is only examined while the switch is commanded on. It latches a flag and raises a channel-off signal that the PWM gate uses to force the switch open. The latch stays set until a clear request arrives while that channel is commanded off.

A single clear input serves every channel. A per-channel mask lets software stop shorts from being reported on channels run at low current limits, where the comparator gives false alarms.

Top module: `lsw_fault_supervisor`

## Requirements
- R1: The open flag of a channel rises at the clock edge that samples the channel commanded off (sw_cmd bit 0) with its open comparator high for the PERSIST-th consecutive time (default 4). An open comparator that is high while the switch is commanded on never sets the flag.
- R2: The open flag is not latched. It drops at the first edge that samples the comparator low or the switch commanded on, and the clear request has no effect on it.
- R3: The short flag of a channel sets at the edge that samples the switch commanded on (sw_cmd bit 1), the short comparator high and the mask low for the PERSIST-th consecutive time. A short comparator that is high while the switch is commanded off never sets it.
- R4: Once set, the short flag stays set, including after the comparator returns low, until a clear request is sampled while the channel is commanded off.
- R5: A clear request sampled while the channel is commanded on leaves its short flag set.
- R6: One clear request drops the short flags of every channel that is commanded off at that edge.
- R7: While a channel's short mask bit is 1, its short flag and channel-off output stay low. The consecutive-cycle count restarts from zero once the mask is released.
- R8: When a clear request falls in the same cycle as a short detection on another channel, the detecting channel ends with its flag set and the commanded-off channels are cleared.
- R9: The channel-off output of a channel is high exactly while that channel's short flag is set.
- R10: After reset every open flag, short flag and channel-off output is 0.
- R11: A single sampled low on a comparator between qualifying cycles restarts the count, so PERSIST-1 qualifying samples, one gap, and PERSIST-1 more samples set no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; each rising edge is one filter tick |
| rst_n | input | 1 | Asynchronous reset, active low |
| sw_cmd | input | NUM_CH | Commanded switch state per channel, 1 = on (closed) |
| open_raw | input | NUM_CH | Raw open-load comparator per channel |
| short_raw | input | NUM_CH | Raw short comparator per channel |
| short_mask | input | NUM_CH | 1 = short reporting suppressed on that channel |
| clear_all | input | 1 | Request to clear the short flags of all channels |
| open_flag | output | NUM_CH | Filtered open-load indication |
| short_flag | output | NUM_CH | Latched short indication |
| ch_off | output | NUM_CH | Forces the channel's PWM output off |

## Verification
The collision that matters is between the global clear and a short detection. Within one channel the two cannot meet, because detection needs the switch on and clearing needs it off. Across channels they can: the bench brings one channel to its fourth qualifying sample exactly as clear_all pulses while another channel holds a latched short with its switch off. It then expects the first channel's flag set and the second cleared. Random runs with sticky comparator inputs and sparse clear pulses produce more of these coincidences, and each one is judged against a per-channel reference model.

// File: rtl/lsw_fault_pkg.sv
package lsw_fault_pkg;

    localparam int unsigned DEF_NUM_CH  = 8;
    localparam int unsigned DEF_PERSIST = 4;

    // Per-channel result bundle handed from a channel slice to the top.
    typedef struct packed {
        logic open_flag;
        logic short_flag;
        logic ch_off;
    } ch_status_t;

endpackage

// File: rtl/lsw_persist_filter.sv
// Consecutive-sample qualifier: hit_next is high when the sample taken at
// this edge completes a run of LEN qualifying samples (or extends it).
module lsw_persist_filter #(
    parameter int unsigned LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic qual,
    output logic hit_next
);
    localparam int unsigned    CW    = (LEN < 1) ? 1 : $clog2(LEN + 1);
    localparam logic [CW-1:0]  LIMIT = CW'(LEN);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } filt_state_t;

    filt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!qual) begin
            st_d.cnt = '0;
        end else if (st_q.cnt != LIMIT) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    assign hit_next = (st_d.cnt == LIMIT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/lsw_fault_channel.sv
module lsw_fault_channel
    import lsw_fault_pkg::*;
#(
    parameter int unsigned PERSIST = DEF_PERSIST
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sw_on,
    input  logic       open_cmp,
    input  logic       short_cmp,
    input  logic       short_mask,
    input  logic       clear_req,
    output ch_status_t status
);
    typedef struct packed {
        logic open_flag;
        logic short_latched;
    } ch_state_t;

    ch_state_t st_d, st_q;

    logic open_qual, short_qual;
    logic open_hit, short_hit;

    // Open load is only meaningful with the switch off, shorts only with it on.
    assign open_qual  = !sw_on && open_cmp;
    assign short_qual = sw_on && short_cmp && !short_mask;

    lsw_persist_filter #(.LEN(PERSIST)) u_open_filt (
        .clk      (clk),
        .rst_n    (rst_n),
        .qual     (open_qual),
        .hit_next (open_hit)
    );

    lsw_persist_filter #(.LEN(PERSIST)) u_short_filt (
        .clk      (clk),
        .rst_n    (rst_n),
        .qual     (short_qual),
        .hit_next (short_hit)
    );

    always_comb begin
        st_d           = st_q;
        st_d.open_flag = open_hit;
        // Detection outranks clearing; clearing needs the switch commanded off.
        if (short_hit) begin
            st_d.short_latched = 1'b1;
        end else if (clear_req && !sw_on) begin
            st_d.short_latched = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status.open_flag  = st_q.open_flag;
    assign status.short_flag = st_q.short_latched;
    assign status.ch_off     = st_q.short_latched;

endmodule

// File: rtl/lsw_fault_supervisor.sv
module lsw_fault_supervisor
    import lsw_fault_pkg::*;
#(
    parameter int unsigned NUM_CH  = DEF_NUM_CH,
    parameter int unsigned PERSIST = DEF_PERSIST
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] sw_cmd,
    input  logic [NUM_CH-1:0] open_raw,
    input  logic [NUM_CH-1:0] short_raw,
    input  logic [NUM_CH-1:0] short_mask,
    input  logic              clear_all,
    output logic [NUM_CH-1:0] open_flag,
    output logic [NUM_CH-1:0] short_flag,
    output logic [NUM_CH-1:0] ch_off
);
    ch_status_t stat [NUM_CH];

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        lsw_fault_channel #(.PERSIST(PERSIST)) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .sw_on      (sw_cmd[ch]),
            .open_cmp   (open_raw[ch]),
            .short_cmp  (short_raw[ch]),
            .short_mask (short_mask[ch]),
            .clear_req  (clear_all),
            .status     (stat[ch])
        );

        assign open_flag[ch]  = stat[ch].open_flag;
        assign short_flag[ch] = stat[ch].short_flag;
        assign ch_off[ch]     = stat[ch].ch_off;
    end

endmodule

// File: rtl/lsw_fault_checker.sv
module lsw_fault_checker #(
    parameter int unsigned NCH = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic [NCH-1:0] sw_cmd,
    input logic [NCH-1:0] open_raw,
    input logic [NCH-1:0] short_raw,
    input logic [NCH-1:0] short_mask,
    input logic           clear_all,
    input logic [NCH-1:0] open_flag,
    input logic [NCH-1:0] short_flag,
    input logic [NCH-1:0] ch_off
);
    for (genvar i = 0; i < NCH; i++) begin : g_chk
        AST_OPEN_NEEDS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
            open_flag[i] |-> $past(!sw_cmd[i] && open_raw[i])); // R1

        AST_OPEN_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            (sw_cmd[i] || !open_raw[i]) |=> !open_flag[i]); // R2

        AST_SHORT_NEEDS_ON: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(short_flag[i]) |-> $past(sw_cmd[i] && short_raw[i])); // R3

        AST_SHORT_HELD_ON: assert property (@(posedge clk) disable iff (!rst_n)
            (short_flag[i] && sw_cmd[i]) |=> short_flag[i]); // R5

        AST_SHORT_CLEAR_PATH: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(short_flag[i]) |-> $past(clear_all && !sw_cmd[i])); // R4

        AST_MASK_BLOCKS_SET: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(short_flag[i]) |-> $past(!short_mask[i])); // R7

        AST_OFF_MATCHES_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ch_off[i]) |-> $rose(short_flag[i])); // R9
    end
endmodule

bind lsw_fault_supervisor lsw_fault_checker #(.NCH(NUM_CH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sw_cmd     (sw_cmd),
    .open_raw   (open_raw),
    .short_raw  (short_raw),
    .short_mask (short_mask),
    .clear_all  (clear_all),
    .open_flag  (open_flag),
    .short_flag (short_flag),
    .ch_off     (ch_off)
);

// File: tb/lsw_fault_supervisor_tb.sv
module lsw_fault_supervisor_tb;
    localparam int NCH        = 8;
    localparam int PER        = 4;
    localparam int CLK_PERIOD = 10;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NCH-1:0] sw_cmd = '0, open_raw = '0, short_raw = '0, short_mask = '0;
    logic           clear_all = 1'b0;
    logic [NCH-1:0] open_flag, short_flag, ch_off;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 0;

    int  m_ocnt [NCH];
    int  m_scnt [NCH];
    bit  m_open [NCH];
    bit  m_short[NCH];

    always #(CLK_PERIOD/2) clk = ~clk;

    lsw_fault_supervisor #(.NUM_CH(NCH), .PERSIST(PER)) u_dut (
        .clk(clk), .rst_n(rst_n), .sw_cmd(sw_cmd), .open_raw(open_raw),
        .short_raw(short_raw), .short_mask(short_mask), .clear_all(clear_all),
        .open_flag(open_flag), .short_flag(short_flag), .ch_off(ch_off)
    );

    function automatic int sat_next(input int cnt, input bit q);
        if (!q) return 0;
        return (cnt >= PER) ? PER : cnt + 1;
    endfunction

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < NCH; i++) begin
            m_ocnt[i] = 0; m_scnt[i] = 0; m_open[i] = 0; m_short[i] = 0;
        end
    endtask

    // Reference from the requirements, fed with the inputs sampled at the edge.
    task automatic model_edge();
        for (int i = 0; i < NCH; i++) begin
            m_ocnt[i] = sat_next(m_ocnt[i], !sw_cmd[i] && open_raw[i]);
            m_scnt[i] = sat_next(m_scnt[i], sw_cmd[i] && short_raw[i] && !short_mask[i]);
            m_open[i] = (m_ocnt[i] == PER);
            if (m_scnt[i] == PER) m_short[i] = 1;
            else if (clear_all && !sw_cmd[i]) m_short[i] = 0;
        end
    endtask

    task automatic compare_all();
        for (int i = 0; i < NCH; i++) begin
            chk($sformatf("R1 open ch%0d", i), open_flag[i], m_open[i]);
            chk($sformatf("R3 short ch%0d", i), short_flag[i], m_short[i]);
            chk($sformatf("R9 off ch%0d", i), ch_off[i], m_short[i]);
        end
    endtask

    task automatic step(input int n = 1);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            model_edge();
            @(negedge clk);
            compare_all();
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog R10: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(negedge clk);
        for (int i = 0; i < NCH; i++) begin
            chk("R10 reset open", open_flag[i], 1'b0);
            chk("R10 reset short", short_flag[i], 1'b0);
            chk("R10 reset off", ch_off[i], 1'b0);
        end
        rst_n = 1'b1;
        step(2);

        // R1: four consecutive off-state open samples
        open_raw[0] = 1;
        step(3); chk("R1 open before 4th sample", open_flag[0], 1'b0);
        step(1); chk("R1 open on 4th sample", open_flag[0], 1'b1);
        // R2: self clear, clear request ignored
        clear_all = 1; step(1); clear_all = 0;
        chk("R2 clear_all leaves open flag", open_flag[0], 1'b1);
        open_raw[0] = 0; step(1); chk("R2 open drops when condition gone", open_flag[0], 1'b0);
        open_raw[0] = 1; step(4); chk("R1 open set again", open_flag[0], 1'b1);
        sw_cmd[0] = 1; step(1); chk("R2 open drops when switched on", open_flag[0], 1'b0);
        step(5); chk("R1 open ignored while on", open_flag[0], 1'b0);
        open_raw[0] = 0; sw_cmd[0] = 0;

        // R11: a single gap restarts the count
        sw_cmd[1] = 1; short_raw[1] = 1; step(3);
        short_raw[1] = 0; step(1);
        short_raw[1] = 1; step(3);
        chk("R11 gap restarts short count", short_flag[1], 1'b0);
        step(1);
        chk("R11 short after 4 unbroken", short_flag[1], 1'b1);
        chk("R9 channel off with short", ch_off[1], 1'b1);

        // R5: clear ignored while commanded on; R4: held after comparator drops
        short_raw[1] = 0; clear_all = 1; step(1); clear_all = 0;
        chk("R5 clear ignored while on", short_flag[1], 1'b1);

        // R3 negative: short while off
        short_raw[2] = 1; step(6);
        chk("R3 short ignored while off", short_flag[2], 1'b0);
        short_raw[2] = 0;

        // R6: one clear drops several channels
        sw_cmd[3] = 1; short_raw[3] = 1; step(4);
        chk("R3 ch3 short set", short_flag[3], 1'b1);
        sw_cmd[1] = 0; sw_cmd[3] = 0; short_raw[3] = 0; step(3);
        chk("R4 ch1 held without clear", short_flag[1], 1'b1);
        chk("R4 ch3 held without clear", short_flag[3], 1'b1);
        clear_all = 1; step(1); clear_all = 0;
        chk("R6 ch1 cleared", short_flag[1], 1'b0);
        chk("R6 ch3 cleared", short_flag[3], 1'b0);
        chk("R9 ch3 off released", ch_off[3], 1'b0);

        // R7: mask suppresses, count restarts on release
        short_mask[4] = 1; sw_cmd[4] = 1; short_raw[4] = 1; step(8);
        chk("R7 masked short flag", short_flag[4], 1'b0);
        chk("R7 masked channel off", ch_off[4], 1'b0);
        short_mask[4] = 0; step(3);
        chk("R7 count restarted after unmask", short_flag[4], 1'b0);
        step(1);
        chk("R7 short after unmask run", short_flag[4], 1'b1);
        sw_cmd[4] = 0; short_raw[4] = 0;

        // R8: clear in the same cycle as a detection on another channel
        sw_cmd[6] = 1; short_raw[6] = 1; step(3);
        clear_all = 1; step(1); clear_all = 0;
        chk("R8 detecting channel stays set", short_flag[6], 1'b1);
        chk("R8 off channel cleared", short_flag[4], 1'b0);
        sw_cmd = '0; short_raw = '0; step(1);
        clear_all = 1; step(1); clear_all = 0;

        // Random phase with sticky inputs
        for (int c = 0; c < 3000; c++) begin
            for (int i = 0; i < NCH; i++) begin
                if ($urandom_range(15) == 0) sw_cmd[i] = ~sw_cmd[i];
                if ($urandom_range(7) == 0) open_raw[i] = ~open_raw[i];
                if ($urandom_range(7) == 0) short_raw[i] = ~short_raw[i];
                if ($urandom_range(63) == 0) short_mask[i] = ~short_mask[i];
            end
            clear_all = ($urandom_range(24) == 0);
            step(1);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule